// File: doc/BRIEF.md
# Leap-Cycle Square-Wave Divider

This block produces a square wave close to 32768 Hz from a 10 MHz reference clock. A prescaler makes a tick every four enabled reference cycles, which gives 2.5 million ticks per second. The ideal half-period is then 2,500,000/65536 ticks, which is 38.1470… ticks, or exactly 0x26.25A in hexadecimal. The output therefore toggles after either 38 or 39 ticks.

Which length comes next is set by a 16-bit fractional accumulator. The accumulator takes the 10-bit fraction, shifted up to 0x25A0, once at every output edge. A carry out of that addition makes the next half-period one tick longer. The addition repeats exactly after 2048 edges, so in every such run 301 half-periods are long, and the long-term frequency is exact with respect to the reference.

A one-cycle strobe marks each edge that begins a long half-period. An enable input freezes the whole divider without losing phase.

Top module: `lhg_toggle_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `sq_out` and `long_stb` are low. The first half-period after reset lasts 38 ticks.
- R2: A tick occurs once every PRESCALE enabled reference cycles, with PRESCALE = 4 by default. A half-period of L ticks lasts exactly PRESCALE×L enabled cycles, and the next half-period starts counting in the cycle after the edge, so no cycles are lost between half-periods.
- R3: Every half-period is either 38 or 39 ticks long.
- R4: At each output edge, 0x25A0 is added modulo 2^16 to a 16-bit accumulator that starts at zero. If that addition carries out of bit 15, the half-period that starts at this edge is 39 ticks; otherwise it is 38.
- R5: `long_stb` is high for exactly the one reference cycle in which `sq_out` shows a new level, and only when the half-period starting there is 39 ticks. It is low in every other cycle.
- R6: Any 2048 consecutive half-periods, starting at the second one after reset or later, add up to 2048×38 + 301 ticks.
- R7: While `en` is low, the prescaler, the tick counter and the accumulator hold their values, `sq_out` does not change, and `long_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (10 MHz in the intended use) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the divider when high |
| sq_out | output | 1 | Square-wave output |
| long_stb | output | 1 | One-cycle pulse at each edge that begins a 39-tick half-period |

## Verification
The bound assertions check, on every cycle, the properties that hold locally:
- the reset levels;
- that the output stays frozen and the strobe stays low while disabled;
- that the strobe only coincides with an output edge;
- that an edge only follows a tick;
- that the tick counter stays within its legal range.

Only the bench scenarios can show the properties that depend on history:
- the exact length of each half-period against an arithmetic model of the accumulator;
- the choice between 38 and 39 ticks after each carry;
- the 301-in-2048 total over sliding windows.

The bench runs a single-cycle prescaler configuration through more than a full 2048-edge cycle with enable gaps. The default divide-by-4 instance runs alongside it, and reset is then applied again mid-run.

// File: rtl/lhg_pkg.sv
package lhg_pkg;
    parameter int unsigned LHG_ACC_W   = 16;
    parameter int unsigned LHG_BASE    = 38;
    parameter int unsigned LHG_CNT_W   = $clog2(LHG_BASE + 2);

    typedef struct packed {
        logic sq;
        logic stb;
    } out_regs_t;
endpackage

// File: rtl/lhg_prescaler.sv
module lhg_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (en) begin
            if (pre_q == LAST) begin
                pre_d = '0;
                tick  = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end
endmodule

// File: rtl/lhg_leap_acc.sv
module lhg_leap_acc #(
    parameter int unsigned           ACC_W = 16,
    parameter logic [ACC_W-1:0]      INC   = 16'h25A0
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic leap
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, INC};
        leap  = sum[ACC_W];
        acc_d = step ? sum[ACC_W-1:0] : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end
endmodule

// File: rtl/lhg_halfper.sv
module lhg_halfper #(
    parameter int unsigned BASE  = 38,
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             leap,
    output logic             toggle,
    output logic [CNT_W-1:0] remain_q
);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BASE);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(BASE + 1);

    logic [CNT_W-1:0] remain_d;

    always_comb begin
        remain_d = remain_q;
        toggle   = tick && (remain_q == CNT_W'(1));
        if (toggle)    remain_d = leap ? LEN_LONG : LEN_SHORT;
        else if (tick) remain_d = remain_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) remain_q <= LEN_SHORT;
        else     remain_q <= remain_d;
    end
endmodule

// File: rtl/lhg_toggle_gen.sv
module lhg_toggle_gen
    import lhg_pkg::*;
#(
    parameter int unsigned      PRESCALE   = 4,
    parameter int unsigned      BASE_TICKS = LHG_BASE,
    parameter int unsigned      ACC_W      = LHG_ACC_W,
    parameter logic [ACC_W-1:0] FRAC_INC   = 16'h25A0
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic en,
    output logic sq_out,
    output logic long_stb
);
    localparam int unsigned CNT_W = $clog2(BASE_TICKS + 2);

    logic             tick;
    logic             leap;
    logic             toggle;
    logic [CNT_W-1:0] remain_q;
    out_regs_t        o_d, o_q;

    lhg_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk_ref), .rst(rst), .en(en), .tick(tick)
    );

    lhg_leap_acc #(.ACC_W(ACC_W), .INC(FRAC_INC)) u_acc (
        .clk(clk_ref), .rst(rst), .step(toggle), .leap(leap)
    );

    lhg_halfper #(.BASE(BASE_TICKS), .CNT_W(CNT_W)) u_hp (
        .clk(clk_ref), .rst(rst), .tick(tick), .leap(leap),
        .toggle(toggle), .remain_q(remain_q)
    );

    always_comb begin
        o_d     = o_q;
        o_d.sq  = toggle ? ~o_q.sq : o_q.sq;
        o_d.stb = toggle && leap;
    end

    always_ff @(posedge clk_ref) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign sq_out   = o_q.sq;
    assign long_stb = o_q.stb;
endmodule

// File: rtl/lhg_toggle_gen_chk.sv
module lhg_toggle_gen_chk #(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned BASE  = 38
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             sq,
    input logic             stb,
    input logic             tick,
    input logic [CNT_W-1:0] remain
);
    AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!sq && !stb)); // R1
    AST_EDGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (sq != $past(sq)) |-> $past(tick)); // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (remain >= CNT_W'(1)) && (remain <= CNT_W'(BASE + 1))); // R3
    AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        stb |-> (sq != $past(sq))); // R5
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sq) && !stb)); // R7
endmodule

bind lhg_toggle_gen lhg_toggle_gen_chk #(.CNT_W(CNT_W), .BASE(BASE_TICKS)) u_chk (
    .clk(clk_ref), .rst(rst), .en(en), .sq(sq_out), .stb(long_stb),
    .tick(tick), .remain(remain_q)
);

// File: tb/lhg_toggle_gen_bench.sv
module lhg_mon #(
    parameter int SCALE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sq,
    input  logic stb,
    output int   n_chk,
    output int   n_err,
    output int   halves
);
    localparam int WIN = 2048;
    localparam int WIN_TICKS = WIN * 38 + 301;

    logic en_used = 1'b0;
    logic rst_used = 1'b1;
    logic sq_prev = 1'b0;
    int   ecnt = 0;
    int   acc_m = 0;
    int   cur_len = 38;
    int   winsum = 0;
    int   hist [0:4095];

    initial begin n_chk = 0; n_err = 0; halves = 0; end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s scale=%0d half=%0d actual=%0d expected=%0d", req, SCALE, halves, act, exp);
        end
    endtask

    always @(posedge clk) begin
        en_used  <= en;
        rst_used <= rst;
    end

    always @(negedge clk) begin
        if (rst_used) begin
            acc_m = 0; cur_len = 38; ecnt = 0; halves = 0; winsum = 0;
            chk(!sq && !stb, "R1 reset outputs", {30'd0, sq, stb}, 0);
            sq_prev = sq;
        end else begin
            if (en_used) ecnt++;
            else chk(sq == sq_prev && !stb, "R7 frozen while disabled", {30'd0, sq, stb}, {31'd0, sq_prev} << 1);
            if (sq != sq_prev) begin
                int sum;
                bit carry;
                if (halves == 0) chk(ecnt == 38 * SCALE, "R1 first half-period", ecnt, 38 * SCALE);
                chk(ecnt == cur_len * SCALE, "R2 R4 half-period length", ecnt, cur_len * SCALE);
                chk(ecnt == 38 * SCALE || ecnt == 39 * SCALE, "R3 length 38 or 39", ecnt / SCALE, 38);
                halves++;
                hist[halves % 4096] = ecnt / SCALE;
                winsum += ecnt / SCALE;
                if (halves > WIN) begin
                    winsum -= hist[(halves - WIN) % 4096];
                    chk(winsum == WIN_TICKS, "R6 window total", winsum, WIN_TICKS);
                end
                sum   = acc_m + 9632;
                carry = (sum >= 65536);
                acc_m = sum % 65536;
                chk(stb == carry, "R5 strobe at edge", {31'd0, stb}, {31'd0, carry});
                cur_len = carry ? 39 : 38;
                ecnt = 0;
            end else if (stb) begin
                chk(1'b0, "R5 strobe without edge", 1, 0);
            end
            sq_prev = sq;
        end
    end
endmodule

module lhg_toggle_gen_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sq1, stb1, sq4, stb4;
    int   c1, e1, h1, c4, e4, h4;
    int   xchk = 0;
    int   xerr = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    lhg_toggle_gen #(.PRESCALE(1)) u_lhg_toggle_gen (
        .clk_ref(clk), .rst(rst), .en(en), .sq_out(sq1), .long_stb(stb1)
    );
    lhg_toggle_gen u_lhg_toggle_gen_div4 (
        .clk_ref(clk), .rst(rst), .en(en), .sq_out(sq4), .long_stb(stb4)
    );

    lhg_mon #(.SCALE(1)) u_mon1 (.clk(clk), .rst(rst), .en(en), .sq(sq1), .stb(stb1),
                                 .n_chk(c1), .n_err(e1), .halves(h1));
    lhg_mon #(.SCALE(4)) u_mon4 (.clk(clk), .rst(rst), .en(en), .sq(sq4), .stb(stb4),
                                 .n_chk(c4), .n_err(e4), .halves(h4));

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", c1 + c4 + xchk, e1 + e4 + xerr);
            $finish;
        end
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        // long run with periodic enable gaps (R7), covering more than 2048 edges (R6)
        while (h1 < 2100) begin
            en = !((cyc % 53) < 3);
            cyc++;
            @(negedge clk);
        end
        // the slow instance covered many half-periods meanwhile (R2)
        xchk++;
        if (h4 < 400) begin
            xerr++;
            $display("FAIL R2 divide-by-4 progress actual=%0d expected=%0d", h4, 400);
        end
        // reset again mid-run (R1)
        en = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        while (h1 < 6 || h4 < 3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        xchk++;
        xerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", h1, 2100);
        finish_run();
    end
endmodule